// File: doc/BRIEF.md
# Dual-Format Serial Audio Transmitter

This block sends stereo samples of 18 bits over a three-wire serial audio link. The bit clock and the word-select clock arrive from outside, so the block always works as a clock follower. It samples both clocks into its own system clock domain and changes its serial data output only after it sees a falling bit-clock edge. A static mode input selects the frame format. Mode 0 is left-justified: the left channel is marked by word-select high, and the MSB is placed in the first bit period of a slot. Mode 1 is the I2S-compatible format: the left channel is marked by word-select low, and the MSB is delayed by one bit period. Every channel slot is 32 bit periods long. The 18 data bits go out MSB first, and the rest of the slot is padded with zeros.

Sample pairs arrive on a parallel port with a valid/ready handshake, and one pending pair is buffered. At the start of each left slot, a pending pair becomes the pair being sent. If no new pair has arrived, the previous pair is sent again. After reset, the serial data line stays low until one full word-select period has passed, so a partial frame is never sent. The control state machine has four states:
- `ST_IDLE` waits for the first start of a left slot, then moves to `ST_MEASURE`.
- `ST_MEASURE` lets one full frame pass, then moves to `ST_LEFT` at the next start of a left slot. This move latches a sample pair.
- `ST_LEFT` moves to `ST_RIGHT` on the next word-select change.
- `ST_RIGHT` moves back to `ST_LEFT` on the next word-select change, which again latches a pair.

Word-select is read at falling bit-clock edges. It is expected to change together with a falling edge.

Top module: `dual_fmt_audio_tx`

## Requirements
- R1: During and directly after reset, `sdata` is low and `in_ready` is high.
- R2: `sdata` stays low until the second start of a left slot after reset, which is one full word-select period after the first one.
- R3: With `fmt_i2s`=0, word-select high marks the left slot. Data bit k (k=0 for the MSB) is valid in the bit period that begins k falling edges after the falling edge at which word-select changed.
- R4: With `fmt_i2s`=1, word-select low marks the left slot. Data bit k is valid in the bit period that begins k+1 falling edges after the word-select change, so the MSB comes one bit period late.
- R5: Each frame carries the left sample and then the right sample. In each 32-period slot, `sdata` is low in every bit period that does not hold one of the 18 data bits.
- R6: `sdata` changes only in response to a detected falling edge of `sclk_in`. It stays constant across every rising edge of `sclk_in`.
- R7: A pair is accepted on a clock where `in_valid` and `in_ready` are both high. `in_ready` then stays low until that pair is latched at the next start of a left slot.
- R8: If no pair is pending at the start of a left slot, the previous pair is sent again. Before any pair has been accepted, zeros are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i2s | input | 1 | Format select: 0 left-justified, 1 I2S-compatible; change only in reset |
| sclk_in | input | 1 | External bit clock |
| lrck_in | input | 1 | External word-select clock |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Pending buffer is empty |
| in_left | input | SAMPLE_W | Left sample |
| in_right | input | SAMPLE_W | Right sample |
| sdata | output | 1 | Serial data output |

## Verification
The bench uses the default parameters: 18-bit samples, 32-period slots and two synchronizer stages. It runs each bit period for eight system clocks, so the two-stage synchronizer and the output register both fit well inside half a bit period. These values let every bit of every slot be compared against a behavioural model in both formats. The run includes a partial slot before the first left start, the quiet frame, frames that reuse a pair, and two pairs offered back to back, where the second must wait for the buffer to drain.

// File: rtl/audtx_pkg.sv
package audtx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MEASURE = 2'd1,
        ST_LEFT    = 2'd2,
        ST_RIGHT   = 2'd3
    } audtx_state_e;

endpackage

// File: rtl/audtx_sync.sv
module audtx_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/audtx_sample_buf.sv
module audtx_sample_buf #(
    parameter int SAMPLE_W = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic                load_req,
    output logic [SAMPLE_W-1:0] word_left,
    output logic [SAMPLE_W-1:0] word_right
);
    logic                pend_full;
    logic [SAMPLE_W-1:0] pend_left, pend_right;
    logic [SAMPLE_W-1:0] act_left, act_right;
    logic                take;

    assign in_ready = !pend_full;
    assign take     = load_req && pend_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_full  <= 1'b0;
            pend_left  <= '0;
            pend_right <= '0;
            act_left   <= '0;
            act_right  <= '0;
        end else if (in_valid && !pend_full) begin
            pend_full  <= 1'b1;
            pend_left  <= in_left;
            pend_right <= in_right;
        end else if (take) begin
            pend_full <= 1'b0;
            act_left  <= pend_left;
            act_right <= pend_right;
        end
    end

    assign word_left  = take ? pend_left  : act_left;
    assign word_right = take ? pend_right : act_right;
endmodule

// File: rtl/audtx_frame_fsm.sv
module audtx_frame_fsm
    import audtx_pkg::*;
#(
    parameter int SAMPLE_W = 18,
    parameter int POS_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fmt_i2s,
    input  logic                sclk_s,
    input  logic                lrck_s,
    input  logic [SAMPLE_W-1:0] word_left,
    input  logic [SAMPLE_W-1:0] word_right,
    output logic                load_req,
    output logic                fall_evt,
    output logic                tx_active,
    output logic [POS_W-1:0]    slot_pos,
    output logic                sdata
);
    localparam logic [POS_W-1:0] POS_MAX  = '1;
    localparam logic [POS_W-1:0] DATA_END = POS_W'(SAMPLE_W);

    audtx_state_e        state, state_n;
    logic                sclk_q, lr_q, seen_fall;
    logic [POS_W-1:0]    pos, pos_n, idx;
    logic                left_lvl, boundary, enter_left;
    logic                bit_valid, sdata_n;
    logic [SAMPLE_W-1:0] word, shifted;

    assign fall_evt   = sclk_q && !sclk_s;
    assign left_lvl   = !fmt_i2s;
    assign boundary   = fall_evt && seen_fall && (lrck_s != lr_q);
    assign enter_left = boundary && (lrck_s == left_lvl);

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:    if (enter_left) state_n = ST_MEASURE;
            ST_MEASURE: if (enter_left) state_n = ST_LEFT;
            ST_LEFT:    if (boundary)   state_n = ST_RIGHT;
            ST_RIGHT:   if (enter_left) state_n = ST_LEFT;
        endcase
    end

    assign load_req = enter_left && (state == ST_MEASURE || state == ST_RIGHT);

    always_comb begin
        if (boundary)            pos_n = '0;
        else if (pos == POS_MAX) pos_n = pos;
        else                     pos_n = pos + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sclk_q    <= 1'b0;
            lr_q      <= 1'b0;
            seen_fall <= 1'b0;
            pos       <= '0;
        end else begin
            sclk_q <= sclk_s;
            if (fall_evt) begin
                state     <= state_n;
                lr_q      <= lrck_s;
                seen_fall <= 1'b1;
                if (seen_fall) pos <= pos_n;
            end
        end
    end

    always_comb begin
        if (fmt_i2s) begin
            bit_valid = (pos_n != '0) && (pos_n <= DATA_END);
            idx       = pos_n - 1'b1;
        end else begin
            bit_valid = pos_n < DATA_END;
            idx       = pos_n;
        end
        word    = (state_n == ST_LEFT) ? word_left : word_right;
        shifted = word << idx;
        sdata_n = bit_valid && (state_n == ST_LEFT || state_n == ST_RIGHT)
                  && shifted[SAMPLE_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sdata <= 1'b0;
        else if (fall_evt) sdata <= sdata_n;
    end

    assign tx_active = (state == ST_LEFT) || (state == ST_RIGHT);
    assign slot_pos  = pos;
endmodule

// File: rtl/dual_fmt_audio_tx.sv
module dual_fmt_audio_tx #(
    parameter int SAMPLE_W    = 18,
    parameter int SLOT_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fmt_i2s,
    input  logic                sclk_in,
    input  logic                lrck_in,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic                sdata
);
    localparam int POS_W = $clog2(SLOT_W) + 1;

    logic [1:0]          clk_pins, clk_sync;
    logic                load_req, fall_evt, tx_active;
    logic [POS_W-1:0]    slot_pos;
    logic [SAMPLE_W-1:0] word_left, word_right;

    assign clk_pins = {lrck_in, sclk_in};

    audtx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (clk_pins),
        .q     (clk_sync)
    );

    audtx_sample_buf #(.SAMPLE_W(SAMPLE_W)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_left    (in_left),
        .in_right   (in_right),
        .load_req   (load_req),
        .word_left  (word_left),
        .word_right (word_right)
    );

    audtx_frame_fsm #(.SAMPLE_W(SAMPLE_W), .POS_W(POS_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt_i2s    (fmt_i2s),
        .sclk_s     (clk_sync[0]),
        .lrck_s     (clk_sync[1]),
        .word_left  (word_left),
        .word_right (word_right),
        .load_req   (load_req),
        .fall_evt   (fall_evt),
        .tx_active  (tx_active),
        .slot_pos   (slot_pos),
        .sdata      (sdata)
    );
endmodule

// File: rtl/audtx_checker.sv
module audtx_checker #(
    parameter int SAMPLE_W = 18,
    parameter int POS_W    = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sdata,
    input logic             in_valid,
    input logic             in_ready,
    input logic             fall_evt,
    input logic             tx_active,
    input logic [POS_W-1:0] slot_pos
);
    assert_quiet_until_framed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> !sdata);

    assert_pad_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_pos > POS_W'(SAMPLE_W)) |-> !sdata);

    assert_change_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_evt |=> $stable(sdata));

    assert_ready_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
endmodule

bind dual_fmt_audio_tx audtx_checker #(.SAMPLE_W(SAMPLE_W), .POS_W(POS_W)) u_chk (.*);

// File: tb/dual_fmt_audio_tx_tb.sv
module dual_fmt_audio_tx_tb;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fmt_i2s = 1'b0;
    logic          sclk_in = 1'b1;
    logic          lrck_in = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_left = '0;
    logic [DW-1:0] in_right = '0;
    logic          sdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [DW-1:0] cur_l, cur_r, pend_l, pend_r;
    bit            pend_v, have_last, lr_last;
    int            left_starts, pos;

    always #5 clk = ~clk;

    dual_fmt_audio_tx u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt_i2s  (fmt_i2s),
        .sclk_in  (sclk_in),
        .lrck_in  (lrck_in),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_left  (in_left),
        .in_right (in_right),
        .sdata    (sdata)
    );

    task automatic check(input logic act, input logic exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural model of one falling bit-clock edge: returns expected bit and its tag
    task automatic model_fall(input bit lvl, output logic exp, output string req);
        bit left_lvl = !fmt_i2s;
        logic [DW-1:0] w;
        int idx;
        if (have_last && lvl != lr_last) begin
            pos = 0;
            if (lvl == left_lvl) begin
                left_starts++;
                if (left_starts >= 2 && pend_v) begin
                    cur_l = pend_l; cur_r = pend_r; pend_v = 1'b0;
                end
            end
        end else if (have_last) begin
            pos++;
        end
        have_last = 1'b1;
        lr_last   = lvl;
        w   = (lvl == left_lvl) ? cur_l : cur_r;
        idx = fmt_i2s ? pos - 1 : pos;
        if (left_starts < 2) begin
            exp = 1'b0; req = "R2";
        end else if (idx < 0 || idx >= DW) begin
            exp = 1'b0; req = "R5";
        end else begin
            exp = w[DW-1-idx];
            req = fmt_i2s ? "R4" : "R3";
        end
    endtask

    task automatic bit_period(input bit lvl);
        logic  exp, seen;
        string req;
        @(negedge clk);
        sclk_in = 1'b0;
        lrck_in = lvl;
        model_fall(lvl, exp, req);
        repeat (4) @(negedge clk);
        check(sdata, exp, req, "bit at rising edge");
        seen    = sdata;
        sclk_in = 1'b1;
        repeat (3) @(negedge clk);
        check(sdata, seen, "R6", "held through high phase");
    endtask

    task automatic offer(input logic [DW-1:0] l, input logic [DW-1:0] r);
        @(negedge clk);
        in_valid = 1'b1;
        in_left  = l;
        in_right = r;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        pend_l = l; pend_r = r; pend_v = 1'b1;
        check(in_ready, 1'b0, "R7", "ready low after accept");
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_mode(input bit i2s, input logic [DW-1:0] mask);
        bit left_lvl = !i2s;
        fmt_i2s  = i2s;
        rst_n    = 1'b0;
        sclk_in  = 1'b1;
        lrck_in  = !left_lvl;
        cur_l = '0; cur_r = '0; pend_v = 1'b0;
        have_last = 1'b0; lr_last = 1'b0; left_starts = 0; pos = 0;
        repeat (5) @(negedge clk);
        check(sdata, 1'b0, "R1", "sdata in reset");
        check(in_ready, 1'b1, "R1", "ready in reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(sdata, 1'b0, "R1", "sdata after reset");
        check(in_ready, 1'b1, "R1", "ready after reset");
        // partial right slot before the first left start (R2)
        for (int i = 0; i < 10; i++) bit_period(!left_lvl);
        for (int f = 0; f < 6; f++) begin
            for (int i = 0; i < 32; i++) begin
                if (f == 2 && i == 8)
                    fork
                        begin
                            offer(18'h20000 ^ mask, 18'h2AAAA ^ mask);
                            offer(18'h15555 ^ mask, 18'h1F0F1 ^ mask);
                        end
                    join_none
                bit_period(left_lvl);
            end
            for (int i = 0; i < 32; i++) begin
                if (f == 0 && i == 5)
                    fork
                        offer(18'h3FFFF ^ mask, 18'h00001 ^ mask);
                    join_none
                bit_period(!left_lvl);
            end
        end
        check(in_ready, 1'b1, "R7", "ready after queue drained");
    endtask

    initial begin
        // frame 1 sends A, frame 2 repeats A (R8), frames 3 and 4 send B and C, frame 5 repeats C
        run_mode(1'b0, 18'h00000);
        run_mode(1'b1, 18'h0F0F3);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule